// File: doc/BRIEF.md
# Transmit and Command Queue with Circular Replay

This block is a single first-in first-out queue shared by two kinds of words bound for a serial frame engine. Command words and transmit data words go into the same storage, each entry tagged with one bit that says which kind it is, so the engine sees them in exactly the order software wrote them. The engine pops entries through a valid/ready read port and reads the tag of the head entry, which lets it act on a command at the correct point in a frame.

A circular mode lets a short stored sequence be sent over and over without refilling. While the mode is on, reads walk through the contents but do not remove them. Once the current pass has run dry and the engine says it is idle, the read position jumps back to where it stood when the mode was switched on. Switching the mode off puts the read position back at that same point, so every entry is still in the queue. A flush input empties the queue at once. Level, empty, full and a sticky overflow flag report its state.

Write ports follow valid/ready rules. The command port is always ready. The data port is ready only when no command write is offered in the same cycle, so a data write that meets a command write is held off by its own ready and must be offered again. A full queue does not lower either ready: a write taken while full is dropped and raises the overflow flag. A write taken in the same cycle as a flush is dropped. On the read side, out_data and out_is_cmd hold steady while out_valid is high and out_ready is low.

Top module: `txcmd_queue`

## Requirements
- R1: Entries leave in the order they were accepted. An entry from the command port reads back with out_is_cmd = 1 and one from the data port reads back with out_is_cmd = 0. The 32-bit word comes out unchanged.
- R2: When cmd_valid is high, dat_ready is low, so only the command word is accepted in that cycle. cmd_ready is always high.
- R3: After reset, level = 0, empty = 1, full = 0, overflow = 0 and out_valid = 0. In normal mode, level counts the stored entries, empty = (level == 0), and full = 1 exactly when level equals DEPTH.
- R4: An accepted write while full is dropped, leaves the contents and level unchanged, and sets overflow. Overflow stays set until a flush or a reset.
- R5: A pop request while the queue is empty has no effect: out_valid stays low and level stays 0.
- R6: One cycle after flush is high, level = 0, empty = 1, out_valid = 0 and overflow = 0. A write in the flush cycle is dropped.
- R7: While circ_en is high, pops do not change level or empty. Both keep the values they had in the cycle circ_en rose.
- R8: In circular mode, once every entry of the pass has been read, out_valid goes low. In the cycle after engine_idle is seen high in that state, out_valid returns high and the head is the entry that was at the head when circ_en rose. While engine_idle is low, no reload happens.
- R9: When circ_en falls, the head returns to the entry that was at the head when circ_en rose, and level again shows every stored entry.
- R10: While out_valid is high and out_ready is low, in normal mode and with no flush, out_data and out_is_cmd stay the same in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command port ready, always 1 |
| cmd_data | input | 32 | Command word |
| dat_valid | input | 1 | Data word offered |
| dat_ready | output | 1 | Data port ready, low while cmd_valid is high |
| dat_data | input | 32 | Transmit data word |
| out_valid | output | 1 | Head entry available |
| out_ready | input | 1 | Engine takes the head entry |
| out_data | output | 32 | Word of the head entry |
| out_is_cmd | output | 1 | Head entry is a command |
| flush | input | 1 | Empty the queue |
| circ_en | input | 1 | Circular replay mode |
| engine_idle | input | 1 | Frame engine is idle |
| level | output | $clog2(DEPTH+1) | Visible occupancy |
| empty | output | 1 | Visible level is zero |
| full | output | 1 | Storage holds DEPTH entries |
| overflow | output | 1 | Sticky: a write was dropped while full |

## Verification
The bench goes after the places where pointer bookkeeping usually breaks. It offers two writes at once: a design that takes both would show one extra level. It writes into a full queue: an unguarded write pointer would overwrite the oldest entry, and that shows up as a wrong word on the next pop. It runs a circular pass and checks three things: a design that reloads without waiting for idle would give a valid head too early, one that forgets the snapshot would replay from the wrong entry, and one that lets status move would report a falling level. It also checks that leaving the mode restores the full contents, that a pop with nothing stored does nothing, and that a flush clears overflow as well as the level.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic              is_cmd;
    logic [WORD_W-1:0] word;
  } entry_t;
endpackage

// File: rtl/txq_arb.sv
module txq_arb
  import txq_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              dat_valid,
  input  logic [WORD_W-1:0] dat_data,
  output logic              cmd_ready,
  output logic              dat_ready,
  output logic              push,
  output entry_t            push_entry
);
  // command port wins a same-cycle contest; data must retry
  assign cmd_ready = 1'b1;
  assign dat_ready = ~cmd_valid;
  assign push      = cmd_valid | dat_valid;

  always_comb begin
    if (cmd_valid) begin
      push_entry.is_cmd = 1'b1;
      push_entry.word   = cmd_data;
    end else begin
      push_entry.is_cmd = 1'b0;
      push_entry.word   = dat_data;
    end
  end
endmodule

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  entry_t        wr_entry,
  input  logic [AW-1:0] rd_addr,
  output entry_t        rd_entry
);
  entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_entry;
  end

  assign rd_entry = mem[rd_addr];
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          out_ready,
  input  logic          flush,
  input  logic          circ_en,
  input  logic          engine_idle,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          overflow
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q, save_ptr_q;
  logic [CW-1:0] count_q, live_q, frozen_q;
  logic          circ_q, ovf_q;

  logic          entering, leaving, pop, reload;
  logic [AW-1:0] rd_eff, save_eff;
  logic [CW-1:0] live_eff;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign entering = circ_en & ~circ_q;
  assign leaving  = ~circ_en & circ_q;
  assign rd_eff   = leaving  ? save_ptr_q : rd_ptr_q;
  assign save_eff = entering ? rd_ptr_q   : save_ptr_q;
  assign live_eff = entering ? count_q    : live_q;

  assign full      = (count_q == CAP);
  assign wr_en     = push & ~full & ~flush;
  assign out_valid = circ_en ? (live_eff != '0) : (count_q != '0);
  assign pop       = out_valid & out_ready & ~flush;
  assign reload    = circ_en & (live_eff == '0) & engine_idle;

  assign level    = circ_en ? (entering ? count_q : frozen_q) : count_q;
  assign empty    = (level == '0);
  assign overflow = ovf_q;
  assign wr_addr  = wr_ptr_q;
  assign rd_addr  = rd_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      save_ptr_q <= '0;
      count_q    <= '0;
      live_q     <= '0;
      frozen_q   <= '0;
      circ_q     <= 1'b0;
      ovf_q      <= 1'b0;
    end else if (flush) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      save_ptr_q <= '0;
      count_q    <= '0;
      live_q     <= '0;
      frozen_q   <= '0;
      circ_q     <= circ_en;
      ovf_q      <= 1'b0;
    end else begin
      circ_q <= circ_en;
      if (push & full) ovf_q <= 1'b1;
      if (wr_en) wr_ptr_q <= step_ptr(wr_ptr_q);

      // circular reads leave storage occupied
      if (circ_en) count_q <= count_q + CW'(wr_en);
      else         count_q <= count_q + CW'(wr_en) - CW'(pop);

      if (entering) begin
        frozen_q   <= count_q;
        save_ptr_q <= rd_ptr_q;
      end

      if (reload) begin
        rd_ptr_q <= save_eff;
        live_q   <= count_q + CW'(wr_en);
      end else begin
        rd_ptr_q <= pop ? step_ptr(rd_eff) : rd_eff;
        live_q   <= circ_en ? (live_eff - CW'(pop) + CW'(wr_en)) : '0;
      end
    end
  end
endmodule

// File: rtl/txcmd_queue.sv
module txcmd_queue
  import txq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [WORD_W-1:0] dat_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_is_cmd,
  input  logic              flush,
  input  logic              circ_en,
  input  logic              engine_idle,
  output logic [CW-1:0]     level,
  output logic              empty,
  output logic              full,
  output logic              overflow
);
  logic          push, wr_en;
  entry_t        push_entry, head;
  logic [AW-1:0] wr_addr, rd_addr;

  txq_arb u_arb (
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .dat_valid (dat_valid),
    .dat_data  (dat_data),
    .cmd_ready (cmd_ready),
    .dat_ready (dat_ready),
    .push      (push),
    .push_entry(push_entry)
  );

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .out_ready  (out_ready),
    .flush      (flush),
    .circ_en    (circ_en),
    .engine_idle(engine_idle),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .out_valid  (out_valid),
    .level      (level),
    .empty      (empty),
    .full       (full),
    .overflow   (overflow)
  );

  txq_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_entry(push_entry),
    .rd_addr (rd_addr),
    .rd_entry(head)
  );

  assign out_data   = head.word;
  assign out_is_cmd = head.is_cmd;
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          dat_valid,
  input logic          dat_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_data,
  input logic          out_is_cmd,
  input logic          flush,
  input logic          circ_en,
  input logic [CW-1:0] level,
  input logic          empty,
  input logic          full,
  input logic          overflow
);
  // R2
  arb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !dat_ready);

  // R3
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !circ_en) |-> (level == CW'(DEPTH)));

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush) |=> overflow);

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && !circ_en && !cmd_valid && !dat_valid) |=> (level == '0));

  // R6
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !out_valid && !overflow));

  // R7
  circ_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (circ_en && $past(circ_en) && !$past(flush)) |-> $stable(level));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush && !circ_en)
      |=> ($stable(out_data) && $stable(out_is_cmd)));
endmodule

bind txcmd_queue txq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .dat_valid (dat_valid),
  .dat_ready (dat_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_is_cmd(out_is_cmd),
  .flush     (flush),
  .circ_en   (circ_en),
  .level     (level),
  .empty     (empty),
  .full      (full),
  .overflow  (overflow)
);

// File: tb/txcmd_queue_test.sv
module txcmd_queue_test;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, dat_valid = 0, out_ready = 0;
  logic flush = 0, circ_en = 0, engine_idle = 0;
  logic [31:0] cmd_data = '0, dat_data = '0;
  logic cmd_ready, dat_ready, out_valid, out_is_cmd, empty, full, overflow;
  logic [31:0] out_data;
  logic [CW-1:0] level;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  txcmd_queue #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_is_cmd(out_is_cmd), .flush(flush), .circ_en(circ_en),
    .engine_idle(engine_idle), .level(level), .empty(empty),
    .full(full), .overflow(overflow)
  );

  // op: 0 idle, 1 command write, 2 data write, 3 pop, 4 both writes
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] val;
    logic [3:0]  lvl;
    logic        vld;
    logic        cmd;
    logic [31:0] dat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 32'h0000_00A0, 4'd1, 1'b1, 1'b1, 32'h0000_00A0},
    '{3'd2, 32'h0000_00D1, 4'd2, 1'b1, 1'b1, 32'h0000_00A0},
    '{3'd2, 32'h0000_00D2, 4'd3, 1'b1, 1'b1, 32'h0000_00A0},
    '{3'd3, 32'h0000_0000, 4'd2, 1'b1, 1'b0, 32'h0000_00D1},
    '{3'd4, 32'h0000_00C3, 4'd3, 1'b1, 1'b0, 32'h0000_00D1},
    '{3'd3, 32'h0000_0000, 4'd2, 1'b1, 1'b0, 32'h0000_00D2},
    '{3'd3, 32'h0000_0000, 4'd1, 1'b1, 1'b1, 32'h0000_00C3},
    '{3'd3, 32'h0000_0000, 4'd0, 1'b0, 1'b0, 32'h0000_0000},
    '{3'd3, 32'h0000_0000, 4'd0, 1'b0, 1'b0, 32'h0000_0000},
    '{3'd2, 32'h0000_00E5, 4'd1, 1'b1, 1'b0, 32'h0000_00E5},
    '{3'd3, 32'h0000_0000, 4'd0, 1'b0, 1'b0, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    cmd_valid = 0; dat_valid = 0; out_ready = 0; flush = 0;
  endtask

  task automatic do_flush();
    flush = 1; tick(); flush = 0;
  endtask

  task automatic wr_dat(input logic [31:0] v);
    dat_valid = 1; dat_data = v; tick(); dat_valid = 0;
  endtask

  task automatic wr_cmd(input logic [31:0] v);
    cmd_valid = 1; cmd_data = v; tick(); cmd_valid = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3 reset state
    chk("R3 reset level", 64'(level), 64'd0);
    chk("R3 reset empty", 64'(empty), 64'd1);
    chk("R3 reset full", 64'(full), 64'd0);
    chk("R3 reset overflow", 64'(overflow), 64'd0);
    chk("R3 reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1;
    tick();

    // R1 R2 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      idle_inputs();
      case (VEC[i].op)
        3'd1: begin cmd_valid = 1; cmd_data = VEC[i].val; end
        3'd2: begin dat_valid = 1; dat_data = VEC[i].val; end
        3'd3: out_ready = 1;
        3'd4: begin
          cmd_valid = 1; cmd_data = VEC[i].val;
          dat_valid = 1; dat_data = VEC[i].val ^ 32'h5555_0000;
          #0.5;
          chk("R2 dat_ready low with cmd", 64'(dat_ready), 64'd0);
        end
        default: ;
      endcase
      tick();
      idle_inputs();
      chk($sformatf("R1/R5 vec %0d level", i), 64'(level), 64'(VEC[i].lvl));
      chk($sformatf("R1/R5 vec %0d valid", i), 64'(out_valid), 64'(VEC[i].vld));
      if (VEC[i].vld) begin
        chk($sformatf("R1 vec %0d data", i), 64'(out_data), 64'(VEC[i].dat));
        chk($sformatf("R1 vec %0d tag", i), 64'(out_is_cmd), 64'(VEC[i].cmd));
      end
      chk($sformatf("R3 vec %0d empty", i), 64'(empty), 64'(VEC[i].lvl == 0));
    end

    // R4 fill, overflow, drain
    for (int i = 0; i < DEPTH; i++) wr_dat(32'(100 + i));
    chk("R3 full at depth", 64'(full), 64'd1);
    chk("R3 level at depth", 64'(level), 64'(DEPTH));
    wr_dat(32'd999);
    chk("R4 overflow set", 64'(overflow), 64'd1);
    chk("R4 level unchanged", 64'(level), 64'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      chk("R4 contents intact", 64'(out_data), 64'(100 + i));
      out_ready = 1; tick(); out_ready = 0;
    end
    chk("R4 drained", 64'(out_valid), 64'd0);
    chk("R4 overflow sticky", 64'(overflow), 64'd1);

    // R6 flush with content and a concurrent write
    wr_dat(32'h11); wr_dat(32'h22);
    flush = 1; cmd_valid = 1; cmd_data = 32'h33; tick(); idle_inputs();
    chk("R6 level zero", 64'(level), 64'd0);
    chk("R6 empty", 64'(empty), 64'd1);
    chk("R6 no valid", 64'(out_valid), 64'd0);
    chk("R6 overflow cleared", 64'(overflow), 64'd0);

    // R10 stall holds head
    wr_cmd(32'h77); wr_dat(32'h88);
    tick(); tick();
    chk("R10 head data held", 64'(out_data), 64'h77);
    chk("R10 head tag held", 64'(out_is_cmd), 64'd1);

    // circular replay
    do_flush();
    wr_cmd(32'hC0); wr_dat(32'hD1); wr_dat(32'hD2);
    circ_en = 1; engine_idle = 0;
    for (int i = 0; i < 3; i++) begin
      out_ready = 1; tick(); out_ready = 0;
      chk("R7 level frozen", 64'(level), 64'd3);
      chk("R7 empty frozen", 64'(empty), 64'd0);
      if (i < 2) chk("R7 pass order", 64'(out_data), (i == 0) ? 64'hD1 : 64'hD2);
    end
    chk("R8 pass exhausted", 64'(out_valid), 64'd0);
    tick(); tick();
    chk("R8 no reload while busy", 64'(out_valid), 64'd0);
    engine_idle = 1; tick(); engine_idle = 0;
    chk("R8 reload valid", 64'(out_valid), 64'd1);
    chk("R8 reload head", 64'(out_data), 64'hC0);
    chk("R8 reload tag", 64'(out_is_cmd), 64'd1);
    out_ready = 1; tick(); out_ready = 0;
    chk("R8 second pass advance", 64'(out_data), 64'hD1);
    circ_en = 0; tick();
    chk("R9 head restored", 64'(out_data), 64'hC0);
    chk("R9 level true", 64'(level), 64'd3);
    out_ready = 1; tick();
    chk("R9 next D1", 64'(out_data), 64'hD1);
    tick();
    chk("R9 next D2", 64'(out_data), 64'hD2);
    tick(); out_ready = 0;
    chk("R9 drained", 64'(level), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule